// File: doc/BRIEF.md
# Instruction Cache with Profiling Counters

This block is a small direct-mapped, read-only instruction cache placed between a processor's instruction fetch port and a slower flash read port. Each line holds one 32-bit word. A fetch that finds its word in the cache is answered in the same cycle. A fetch that does not find it is sent to flash. The answer then takes a number of wait states set on an input pin, because the real count depends on the clock frequency. When the flash word returns, it is written into the line chosen by the address.

A small register window controls the block. The configuration word has one bit that turns the cache on and a second bit that turns profiling on. While profiling is on, two counters record hits and misses. Each counter stops at its largest value and never wraps. When the cache is turned off, every fetch goes straight to flash and nothing is counted. All stored lines are also dropped, so the cache starts empty when it is turned on again.

Top module: `icode_cache`

## Requirements
- R1: When the cache is enabled and the fetched address is stored, `fetch_rdy` rises in the same cycle as `fetch_req`, `fetch_data` carries the stored word, and `flash_rd` stays low.
- R2: When the cache is enabled and the address is not stored, `flash_rd` is high from the request cycle onward with `flash_addr` equal to `fetch_addr`. `fetch_rdy` rises exactly `wait_states`+1 cycles after the request cycle, carrying `flash_rdata`.
- R3: After a miss completes, the same address hits. The line is chosen by address bits [5:2] (for 16 lines). An address with the same index but a different upper part replaces the line, so the old address then misses again.
- R4: With the enable bit clear, every fetch takes the flash path with `wait_states`+1 cycles of latency. Nothing is filled, and no counter changes.
- R5: Clearing the enable bit drops all lines. After the bit is set again, a previously stored address misses.
- R6: While the cache and profiling are both enabled, the hit counter (read at offset 0x548) rises by one for each fetch that hits.
- R7: While the cache and profiling are both enabled, the miss counter (read at offset 0x54C) rises by one for each fetch that misses.
- R8: With the profiling bit clear, neither counter changes on hits or misses.
- R9: A counter that has reached its largest value (2^CNT_W−1) stays there and does not wrap.
- R10: The configuration word is at offset 0x540, with bit 0 as cache enable and bit 8 as profiling enable. All other bits read as zero. Writing any value to offset 0x548 or 0x54C clears only that counter.
- R11: After reset, the configuration word and both counters read zero, `fetch_rdy` is low, and all lines are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch request, held with its address until `fetch_rdy` |
| fetch_addr | input | ADDR_W | Byte address of the instruction word |
| fetch_rdy | output | 1 | Fetch answered this cycle |
| fetch_data | output | DATA_W | Instruction word, valid with `fetch_rdy` |
| wait_states | input | WS_W | Flash wait states, sampled at the start of a flash access |
| flash_rd | output | 1 | Flash read in progress |
| flash_addr | output | ADDR_W | Flash read address |
| flash_rdata | input | DATA_W | Flash read data, valid once the wait states have passed |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
A wrong valid bit or stored tag shows at the ports in the very next fetch to that index. A line that should be stored produces a latency of `wait_states`+1 and a `flash_rd` pulse instead of a zero-wait answer. A line that should be empty produces a zero-wait answer with stale data. A wrong miss-state counter shows as an answer one or more cycles early or late. A wrong counter gate or saturation rule shows up the next time the counters are read.

// File: rtl/icc_pkg.sv
package icc_pkg;
   localparam logic [11:0] OFS_CFG    = 12'h540;
   localparam logic [11:0] OFS_HITS   = 12'h548;
   localparam logic [11:0] OFS_MISSES = 12'h54C;
   localparam int          CFG_EN_BIT   = 0;
   localparam int          CFG_PROF_BIT = 8;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } icc_state_e;
endpackage

// File: rtl/icc_line_store.sv
module icc_line_store #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LINES  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              hit,
   output logic [DATA_W-1:0] hit_data,
   input  logic              fill,
   input  logic [DATA_W-1:0] fill_data
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W - 2;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for LINES");
   end

   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   assign idx = lk_addr[IDX_W+1:2];
   assign tag = lk_addr[ADDR_W-1:IDX_W+2];

   logic              valid_q [LINES];
   logic [TAG_W-1:0]  tag_q   [LINES];
   logic [DATA_W-1:0] data_q  [LINES];
   logic [LINES-1:0]  valid_vec;
   logic [LINES-1:0]  fill_sel;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      assign fill_sel[g] = fill && (idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            tag_q[g]   <= '0;
            data_q[g]  <= '0;
         end else if (!enable) begin
            valid_q[g] <= 1'b0;
         end else if (fill_sel[g]) begin
            valid_q[g] <= 1'b1;
            tag_q[g]   <= tag;
            data_q[g]  <= fill_data;
         end
      end
      assign valid_vec[g] = valid_q[g];
   end

   assign hit      = valid_q[idx] && (tag_q[idx] == tag);
   assign hit_data = data_q[idx];

   AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (valid_vec == '0)); // R5
   AST_ONE_LINE_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fill_sel)); // R3
   AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (fill && enable) |=> (valid_vec[$past(idx)] == 1'b1)); // R3
endmodule

// File: rtl/icc_miss_fsm.sv
module icc_miss_fsm
   import icc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WS_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              fetch_req,
   input  logic [WS_W-1:0]   wait_states,
   input  logic              hit,
   input  logic [DATA_W-1:0] hit_data,
   input  logic [DATA_W-1:0] flash_rdata,
   output logic              fetch_rdy,
   output logic [DATA_W-1:0] fetch_data,
   output logic              flash_rd,
   output logic              fill,
   output logic              hit_evt,
   output logic              miss_evt
);
   if (WS_W < 1 || WS_W > 16) begin : g_bad_ws
      $error("WS_W out of range");
   end

   icc_state_e      st_q, st_d;
   logic [WS_W-1:0] cnt_q, cnt_d;
   logic            served;

   assign served = enable && hit;

   always_comb begin
      st_d       = st_q;
      cnt_d      = cnt_q;
      fetch_rdy  = 1'b0;
      fetch_data = hit_data;
      flash_rd   = 1'b0;
      fill       = 1'b0;
      hit_evt    = 1'b0;
      miss_evt   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (fetch_req) begin
               if (served) begin
                  fetch_rdy = 1'b1;
                  hit_evt   = 1'b1;
               end else begin
                  flash_rd = 1'b1;
                  miss_evt = enable;
                  st_d     = ST_WAIT;
                  cnt_d    = wait_states;
               end
            end
         end
         ST_WAIT: begin
            flash_rd = 1'b1;
            if (cnt_q == '0) begin
               fetch_rdy  = 1'b1;
               fetch_data = flash_rdata;
               fill       = enable;
               st_d       = ST_IDLE;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   AST_HIT_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && fetch_req && enable && hit) |-> (fetch_rdy && !flash_rd)); // R1
   AST_MISS_TO_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && fetch_req && !(enable && hit)) |=> (st_q == ST_WAIT && flash_rd)); // R2
   AST_WAIT_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && cnt_q != '0) |=> (st_q == ST_WAIT && cnt_q == $past(cnt_q) - 1'b1)); // R2
   AST_NO_FILL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !fill); // R4
   AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_evt && miss_evt)); // R7
endmodule

// File: rtl/icc_sat_counter.sv
module icc_sat_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] value
);
   if (W < 2 || W > 32) begin : g_bad_w
      $error("counter width out of range");
   end

   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    value <= '0;
      else if (clr)                  value <= '0;
      else if (inc && value != TOP)  value <= value + 1'b1;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (value == TOP && !clr) |=> (value == TOP)); // R9
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (value == $past(value) || value == $past(value) + 1'b1)); // R6
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (value == '0)); // R10
endmodule

// File: rtl/icc_cfg_regs.sv
module icc_cfg_regs
   import icc_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [11:0]      reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic [CNT_W-1:0] hits,
   input  logic [CNT_W-1:0] misses,
   output logic             cache_en,
   output logic             prof_en,
   output logic             clr_hits,
   output logic             clr_misses
);
   logic [31:0] hits_ext, misses_ext, cfg_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cache_en <= 1'b0;
         prof_en  <= 1'b0;
      end else if (reg_we && reg_addr == OFS_CFG) begin
         cache_en <= reg_wdata[CFG_EN_BIT];
         prof_en  <= reg_wdata[CFG_PROF_BIT];
      end
   end

   assign clr_hits   = reg_we && (reg_addr == OFS_HITS);
   assign clr_misses = reg_we && (reg_addr == OFS_MISSES);

   always_comb begin
      hits_ext   = '0;
      misses_ext = '0;
      cfg_word   = '0;
      hits_ext[CNT_W-1:0]    = hits;
      misses_ext[CNT_W-1:0]  = misses;
      cfg_word[CFG_EN_BIT]   = cache_en;
      cfg_word[CFG_PROF_BIT] = prof_en;
      unique case (reg_addr)
         OFS_CFG:    reg_rdata = cfg_word;
         OFS_HITS:   reg_rdata = hits_ext;
         OFS_MISSES: reg_rdata = misses_ext;
         default:    reg_rdata = '0;
      endcase
   end

   AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFS_CFG) |=>
      (cache_en == $past(reg_wdata[CFG_EN_BIT]) && prof_en == $past(reg_wdata[CFG_PROF_BIT]))); // R10
endmodule

// File: rtl/icode_cache.sv
module icode_cache
   import icc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LINES  = 16,
   parameter int WS_W   = 4,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_rdy,
   output logic [DATA_W-1:0] fetch_data,
   input  logic [WS_W-1:0]   wait_states,
   output logic              flash_rd,
   output logic [ADDR_W-1:0] flash_addr,
   input  logic [DATA_W-1:0] flash_rdata,
   input  logic              reg_we,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);
   logic              cache_en, prof_en, clr_hits, clr_misses;
   logic              hit, fill, hit_evt, miss_evt;
   logic [DATA_W-1:0] hit_data;
   logic [CNT_W-1:0]  hits, misses;

   assign flash_addr = fetch_addr;

   icc_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_store (
      .clk(clk), .rst_n(rst_n), .enable(cache_en), .lk_addr(fetch_addr),
      .hit(hit), .hit_data(hit_data), .fill(fill), .fill_data(flash_rdata)
   );

   icc_miss_fsm #(.DATA_W(DATA_W), .WS_W(WS_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .enable(cache_en), .fetch_req(fetch_req),
      .wait_states(wait_states), .hit(hit), .hit_data(hit_data),
      .flash_rdata(flash_rdata), .fetch_rdy(fetch_rdy), .fetch_data(fetch_data),
      .flash_rd(flash_rd), .fill(fill), .hit_evt(hit_evt), .miss_evt(miss_evt)
   );

   icc_sat_counter #(.W(CNT_W)) u_hits (
      .clk(clk), .rst_n(rst_n), .clr(clr_hits), .inc(prof_en && hit_evt), .value(hits)
   );

   icc_sat_counter #(.W(CNT_W)) u_misses (
      .clk(clk), .rst_n(rst_n), .clr(clr_misses), .inc(prof_en && miss_evt), .value(misses)
   );

   icc_cfg_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hits(hits), .misses(misses),
      .cache_en(cache_en), .prof_en(prof_en), .clr_hits(clr_hits), .clr_misses(clr_misses)
   );

   AST_PROF_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!prof_en && !clr_hits && !clr_misses) |=> ($stable(hits) && $stable(misses))); // R8
   AST_OFF_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cache_en && !clr_hits && !clr_misses) |=> ($stable(hits) && $stable(misses))); // R4
   AST_RDY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_rdy && !flash_rd) |-> fetch_req); // R11
endmodule

// File: tb/sim_icode_cache.sv
module sim_icode_cache;
   localparam int CW = 4;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        fetch_rdy;
   logic [31:0] fetch_data;
   logic [3:0]  wait_states = '0;
   logic        flash_rd;
   logic [31:0] flash_addr;
   logic [31:0] flash_rdata;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   function automatic logic [31:0] fdat(input logic [31:0] a);
      return (a * 32'h0001_0003) ^ 32'h5A5A_0F0F;
   endfunction

   assign flash_rdata = fdat(flash_addr);

   icode_cache #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_rdy(fetch_rdy), .fetch_data(fetch_data), .wait_states(wait_states),
      .flash_rd(flash_rd), .flash_addr(flash_addr), .flash_rdata(flash_rdata),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic fetch(input logic [31:0] a, input logic [3:0] ws,
                        output int lat, output logic [31:0] d,
                        output bit used_flash, output bit addr_bad);
      lat = -1; d = '0; used_flash = 1'b0; addr_bad = 1'b0;
      @(negedge clk);
      fetch_addr = a; wait_states = ws; fetch_req = 1'b1;
      for (int c = 0; c < 64; c++) begin
         #1;
         if (flash_rd) begin
            used_flash = 1'b1;
            if (flash_addr !== a) addr_bad = 1'b1;
         end
         if (fetch_rdy) begin
            lat = c;
            d = fetch_data;
            @(posedge clk);
            @(negedge clk);
            fetch_req = 1'b0;
            break;
         end
         @(posedge clk);
         @(negedge clk);
      end
      fetch_req = 1'b0;
   endtask

   // {address, wait states, expect hit}
   localparam logic [36:0] VEC [0:10] = '{
      {32'h0000_0100, 4'd2, 1'b0},
      {32'h0000_0100, 4'd2, 1'b1},
      {32'h0000_0104, 4'd0, 1'b0},
      {32'h0000_0104, 4'd5, 1'b1},
      {32'h0000_0200, 4'd1, 1'b0},
      {32'h0000_0100, 4'd1, 1'b0},
      {32'h0000_0200, 4'd1, 1'b0},
      {32'h0000_013C, 4'd3, 1'b0},
      {32'h0000_013C, 4'd3, 1'b1},
      {32'h0000_0104, 4'd0, 1'b1},
      {32'h0000_0200, 4'd7, 1'b1}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int lat;
      logic [31:0] d, r;
      bit fl, ab;
      int exp_h, exp_m;

      repeat (3) @(posedge clk);
      @(negedge clk);
      #1 check("R11 rdy low after reset", {31'b0, fetch_rdy}, 32'h0);
      rst_n = 1'b1;
      reg_read(12'h540, r); check("R11 cfg reset", r, 32'h0);
      reg_read(12'h548, r); check("R11 hits reset", r, 32'h0);
      reg_read(12'h54C, r); check("R11 misses reset", r, 32'h0);

      // R10 config fields
      reg_write(12'h540, 32'hFFFF_FFFF);
      reg_read(12'h540, r); check("R10 cfg readback", r, 32'h0000_0101);

      // table walk: R1 R2 R3 R6 R7, first fetch also R11 (lines invalid)
      exp_h = 0; exp_m = 0;
      for (int i = 0; i < 11; i++) begin
         logic [31:0] va;
         logic [3:0]  vw;
         logic        vh;
         va = VEC[i][36:5]; vw = VEC[i][4:1]; vh = VEC[i][0];
         fetch(va, vw, lat, d, fl, ab);
         check(vh ? "R1 hit data" : "R2 miss data", d, fdat(va));
         if (vh) begin
            exp_h++;
            check("R1 hit latency", lat, 0);
            check("R1 hit no flash", {31'b0, fl}, 32'h0);
         end else begin
            exp_m++;
            check("R2 miss latency", lat, 32'(vw) + 1);
            check("R2 miss flash addr", {30'b0, fl, ab}, 32'h2);
         end
      end
      reg_read(12'h548, r); check("R6 hit count", r, 32'(exp_h));
      reg_read(12'h54C, r); check("R7 miss count", r, 32'(exp_m));

      // R10 clearing one counter leaves the other
      reg_write(12'h548, 32'h1234);
      reg_read(12'h548, r); check("R10 hits cleared", r, 32'h0);
      reg_read(12'h54C, r); check("R10 misses kept", r, 32'(exp_m));

      // R8 profiling off
      reg_write(12'h540, 32'h0000_0001);
      fetch(32'h104, 4'd0, lat, d, fl, ab);
      check("R8 hit still served", lat, 0);
      fetch(32'h180, 4'd1, lat, d, fl, ab);
      check("R8 miss still served", lat, 2);
      reg_read(12'h548, r); check("R8 hits frozen", r, 32'h0);
      reg_read(12'h54C, r); check("R8 misses frozen", r, 32'(exp_m));

      // R4 cache disabled, profiling on
      reg_write(12'h540, 32'h0000_0100);
      for (int k = 0; k < 2; k++) begin
         fetch(32'h104, 4'd3, lat, d, fl, ab);
         check("R4 bypass latency", lat, 4);
         check("R4 bypass flash", {31'b0, fl}, 32'h1);
         check("R4 bypass data", d, fdat(32'h104));
      end
      reg_read(12'h548, r); check("R4 hits unchanged", r, 32'h0);
      reg_read(12'h54C, r); check("R4 misses unchanged", r, 32'(exp_m));

      // R5 re-enable finds nothing stored
      reg_write(12'h540, 32'h0000_0101);
      fetch(32'h13C, 4'd2, lat, d, fl, ab);
      check("R5 reenable miss", lat, 3);
      reg_read(12'h54C, r); check("R5 miss counted", r, 32'(exp_m + 1));

      // R9 saturation
      reg_write(12'h548, 32'h0);
      reg_write(12'h54C, 32'h0);
      fetch(32'h104, 4'd0, lat, d, fl, ab);
      for (int k = 0; k < 20; k++) fetch(32'h104, 4'd0, lat, d, fl, ab);
      reg_read(12'h548, r); check("R9 hits saturate", r, 32'(CMAX));
      fetch(32'h104, 4'd0, lat, d, fl, ab);
      reg_read(12'h548, r); check("R9 hits stay", r, 32'(CMAX));
      for (int k = 0; k < 17; k++)
         fetch((k % 2) ? 32'h200 : 32'h100, 4'd0, lat, d, fl, ab);
      reg_read(12'h54C, r); check("R9 misses saturate", r, 32'(CMAX));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule